// File: doc/BRIEF.md
# Display Bridge Bring-Up Sequencer

This block walks a parallel-to-serial display bridge through its complete power-up programme, one register access at a time. It drives the bridge's reset pin, can read back two registers to confirm that the control link works, writes the panel timing and pixel format, chooses the PLL reference, starts the PLL, sends two panel commands with programmable waits after each, and at the end switches the data lanes to high-speed and turns the video pipeline on. The serial framing is handled by a separate access master. This block issues one request at a time to that master and waits for its acknowledge.

Readback is not always wired, so the bridge configuration register is held as a shadow copy inside the sequencer. The sequencer writes that register twice. The first write, before the PLL is set up, puts the data lanes in low-power mode with the clock lane in high-speed mode. The second write, after the panel commands, adds high-speed data and video enable. The PLL word and the low-power clock divider come in as ready-made values. Every wait is counted in system clocks, derived from a clock-frequency parameter.

A pulse on `start` runs the programme. At the end `done` or `err` rises and stays high until the next `start`. The inputs must stay stable during a run.

Top module: `bridge_bringup_seq`

## Requirements
- R1: After the synchronous reset, `done`, `err` and `acc_req` are 0 and `bridge_rst_n` is 1.
- R2: After `start`, `bridge_rst_n` is held low for RST_MS milliseconds of clocks. It is then high for at least the same time before the first access is requested. No access is requested while it is low.
- R3: When `readback_en` is 1, the first two accesses are reads of 0xB0 and 0xB7. The data returned must be 0x2828 and then the shadow, which is 0x0301 after reset. A mismatch raises `err` and no further access is issued. When `readback_en` is 0, no read is issued.
- R4: The timing writes come in this order: 0xB1 = {vsync_len, hsync_len}; 0xB2 = {vsync_len+vback, hsync_len+hback}, with each sum truncated to 8 bits; 0xB3 = {vfront, hfront}; 0xB4 = hactive; 0xB5 = vactive. In each pair the first field is the high byte.
- R5: 0xB6 is written with bits 3:2 = 2 (burst) and bits 1:0 = the format code: depth 16 gives 0, depth 18 gives 1 (2 if `loose18`), depth 24 gives 3. Any other depth raises `err` right after the 0xB5 write, and 0xB6 is not written.
- R6: 0xDE is written with `lanes` minus one.
- R7: The first 0xB7 write clears bit 0 and sets bits 1 and 6 of the shadow. Bit 5 is also set when `ref_khz` is 0. This gives 0x0342 or 0x0362.
- R8: The writes 0xBA = `pll_word`, 0xB8 = 0, 0xBB = `lpdiv_word` and 0xB9 = 1 follow in that order. At least LOCK_US microseconds of clocks pass before the next access.
- R9: Each panel command is a write of 1 to 0xBC followed by a write of the command byte to 0xBF: first 0x11 (exit sleep), then 0x29 (display on). These are followed by `dly_sleep_ms` and `dly_disp_ms` milliseconds of clocks respectively, and a value of 0 adds no wait.
- R10: The last access writes 0xB7 with bits 0 and 3 added to the first value (0x034B or 0x036B). `done` then rises, and `done` and `err` are never high together.
- R11: `acc_req` stays high with `acc_wr`, `acc_addr` and `acc_wdata` unchanged until `acc_ack`. It drops in the cycle after the acknowledge, so only one access is outstanding at a time.
- R12: `start` is ignored while a run is in progress. It restarts the programme from the reset step once `done` or `err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin the programme |
| readback_en | input | 1 | Readback path available: run the identity checks |
| hsync_len | input | 8 | Horizontal sync width |
| vsync_len | input | 8 | Vertical sync width |
| hback | input | 8 | Horizontal back porch |
| vback | input | 8 | Vertical back porch |
| hfront | input | 8 | Horizontal front porch |
| vfront | input | 8 | Vertical front porch |
| hactive | input | 16 | Active pixels per line |
| vactive | input | 16 | Active lines per frame |
| depth | input | 5 | Colour depth in bits per pixel |
| loose18 | input | 1 | Use loosely packed 18-bit format |
| lanes | input | 3 | Number of data lanes (1 to 4) |
| pll_word | input | 16 | Precomputed PLL configuration word |
| lpdiv_word | input | 16 | Precomputed low-power clock divider word |
| ref_khz | input | 16 | Reference clock in kHz; 0 selects the pixel clock |
| dly_sleep_ms | input | 8 | Wait after exit-sleep in ms |
| dly_disp_ms | input | 8 | Wait after display-on in ms |
| acc_req | output | 1 | Access request to the register master |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_addr | output | 8 | Bridge register address |
| acc_wdata | output | 16 | Write data |
| acc_ack | input | 1 | Access complete (one cycle) |
| acc_rdata | input | 16 | Read data, valid with `acc_ack` |
| bridge_rst_n | output | 1 | Active-low reset to the bridge |
| done | output | 1 | Programme finished successfully |
| err | output | 1 | Programme aborted |

## Verification
The hardest cases to reach are the waits that lie between accesses rather than on them. These are the lock wait after the PLL enable and the two command delays, including a delay of zero. The bench models the access master with a random acknowledge latency and timestamps every request and acknowledge. The gap between the acknowledge of one access and the request of the next can then be compared with the configured wait, while the handshake timing keeps varying. The early aborts are reached by returning a wrong identity or configuration word from the modelled master and by driving an unsupported depth. In each case the log of accesses must stop at exactly the expected point.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  typedef enum logic [4:0] {
    ST_RST_LO, ST_RST_HI, ST_RD_ID, ST_RD_CFG,
    ST_TM_SYNC, ST_TM_BACK, ST_TM_FRONT, ST_TM_HACT, ST_TM_VACT,
    ST_FMT, ST_LANES, ST_CFG_LP, ST_PLL, ST_VC, ST_LPDIV, ST_PLL_EN,
    ST_LOCK, ST_SZ_A, ST_CMD_A, ST_DLY_A, ST_SZ_B, ST_CMD_B, ST_DLY_B,
    ST_CFG_HS, ST_END
  } step_e;

  typedef enum logic [1:0] {K_WAIT, K_READ, K_WRITE, K_END} kind_e;

  typedef enum logic [1:0] {F_IDLE, F_PREP, F_ACC, F_WAIT} fsm_e;

  localparam int AW = 8;
  localparam int DW = 16;

  localparam logic [AW-1:0] A_ID     = 8'hB0;
  localparam logic [AW-1:0] A_SYNC   = 8'hB1;
  localparam logic [AW-1:0] A_BACK   = 8'hB2;
  localparam logic [AW-1:0] A_FRONT  = 8'hB3;
  localparam logic [AW-1:0] A_HACT   = 8'hB4;
  localparam logic [AW-1:0] A_VACT   = 8'hB5;
  localparam logic [AW-1:0] A_FMT    = 8'hB6;
  localparam logic [AW-1:0] A_CFG    = 8'hB7;
  localparam logic [AW-1:0] A_VC     = 8'hB8;
  localparam logic [AW-1:0] A_PLLEN  = 8'hB9;
  localparam logic [AW-1:0] A_PLL    = 8'hBA;
  localparam logic [AW-1:0] A_LPDIV  = 8'hBB;
  localparam logic [AW-1:0] A_PKTSZ  = 8'hBC;
  localparam logic [AW-1:0] A_PKT    = 8'hBF;
  localparam logic [AW-1:0] A_LANES  = 8'hDE;

  localparam logic [DW-1:0] ID_VALUE  = 16'h2828;
  localparam logic [DW-1:0] CFG_RESET = 16'h0301;

  // configuration register bit positions used by the sequence
  localparam int CB_HSDATA = 0;
  localparam int CB_HSCLK  = 1;
  localparam int CB_VIDEN  = 3;
  localparam int CB_PCLKREF = 5;
  localparam int CB_CMDSET = 6;

  localparam logic [7:0] CMD_EXIT_SLEEP = 8'h11;
  localparam logic [7:0] CMD_DISP_ON    = 8'h29;
  localparam logic [1:0] MODE_BURST     = 2'd2;

endpackage

// File: rtl/bbs_wait_timer.sv
module bbs_wait_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= value;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // a drained counter stays drained until reloaded (R8 waits end once)
  assert_timer_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> (cnt == '0));
endmodule

// File: rtl/bbs_cfg_shadow.sv
module bbs_cfg_shadow
  import bbs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (rst || init) shadow <= CFG_RESET;
    else if (load)   shadow <= load_val;
  end

  // the command-set and clock-lane bits are never cleared once loaded (R7)
  assert_shadow_lp_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (shadow[CB_CMDSET] && shadow[CB_HSCLK]));
endmodule

// File: rtl/bbs_step_decode.sv
module bbs_step_decode
  import bbs_pkg::*;
#(
  parameter int WAIT_W     = 26,
  parameter int CYC_PER_MS = 250000,
  parameter int RST_CYC    = 2500000,
  parameter int LOCK_CYC   = 125000,
  parameter int DLY_W      = 8
) (
  input  step_e             step,
  input  logic              readback_en,
  input  logic [7:0]        hsync_len,
  input  logic [7:0]        vsync_len,
  input  logic [7:0]        hback,
  input  logic [7:0]        vback,
  input  logic [7:0]        hfront,
  input  logic [7:0]        vfront,
  input  logic [15:0]       hactive,
  input  logic [15:0]       vactive,
  input  logic [4:0]        depth,
  input  logic              loose18,
  input  logic [2:0]        lanes,
  input  logic [DW-1:0]     pll_word,
  input  logic [DW-1:0]     lpdiv_word,
  input  logic [15:0]       ref_khz,
  input  logic [DLY_W-1:0]  dly_sleep_ms,
  input  logic [DLY_W-1:0]  dly_disp_ms,
  input  logic [DW-1:0]     shadow,
  output kind_e             kind,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     wdata,
  output logic [DW-1:0]     expect_val,
  output logic [WAIT_W-1:0] wait_cyc,
  output logic              fmt_bad,
  output step_e             next_step
);
  logic [1:0]    fmt;
  logic [7:0]    hsum, vsum;
  logic [DW-1:0] cfg_lp, cfg_hs;

  assign hsum = hsync_len + hback;
  assign vsum = vsync_len + vback;

  always_comb begin
    fmt_bad = 1'b0;
    fmt     = 2'd0;
    case (depth)
      5'd16:   fmt = 2'd0;
      5'd18:   fmt = loose18 ? 2'd2 : 2'd1;
      5'd24:   fmt = 2'd3;
      default: fmt_bad = 1'b1;
    endcase
  end

  always_comb begin
    cfg_lp = shadow;
    cfg_lp[CB_HSDATA] = 1'b0;
    cfg_lp[CB_HSCLK]  = 1'b1;
    cfg_lp[CB_CMDSET] = 1'b1;
    if (ref_khz == '0) cfg_lp[CB_PCLKREF] = 1'b1;
    cfg_hs = shadow;
    cfg_hs[CB_HSDATA] = 1'b1;
    cfg_hs[CB_VIDEN]  = 1'b1;
  end

  always_comb begin
    kind       = K_WRITE;
    addr       = '0;
    wdata      = '0;
    expect_val = '0;
    wait_cyc   = '0;
    next_step  = step_e'(step + 5'd1);
    case (step)
      ST_RST_LO: begin kind = K_WAIT; wait_cyc = WAIT_W'(RST_CYC); end
      ST_RST_HI: begin
        kind      = K_WAIT;
        wait_cyc  = WAIT_W'(RST_CYC);
        next_step = readback_en ? ST_RD_ID : ST_TM_SYNC;
      end
      ST_RD_ID:    begin kind = K_READ; addr = A_ID;  expect_val = ID_VALUE; end
      ST_RD_CFG:   begin kind = K_READ; addr = A_CFG; expect_val = shadow;   end
      ST_TM_SYNC:  begin addr = A_SYNC;  wdata = {vsync_len, hsync_len}; end
      ST_TM_BACK:  begin addr = A_BACK;  wdata = {vsum, hsum};           end
      ST_TM_FRONT: begin addr = A_FRONT; wdata = {vfront, hfront};       end
      ST_TM_HACT:  begin addr = A_HACT;  wdata = hactive;                end
      ST_TM_VACT:  begin addr = A_VACT;  wdata = vactive;                end
      ST_FMT:      begin addr = A_FMT;   wdata = {12'd0, MODE_BURST, fmt}; end
      ST_LANES:    begin addr = A_LANES; wdata = {13'd0, lanes - 3'd1};  end
      ST_CFG_LP:   begin addr = A_CFG;   wdata = cfg_lp;                 end
      ST_PLL:      begin addr = A_PLL;   wdata = pll_word;               end
      ST_VC:       begin addr = A_VC;    wdata = '0;                     end
      ST_LPDIV:    begin addr = A_LPDIV; wdata = lpdiv_word;             end
      ST_PLL_EN:   begin addr = A_PLLEN; wdata = 16'd1;                  end
      ST_LOCK:     begin kind = K_WAIT;  wait_cyc = WAIT_W'(LOCK_CYC);   end
      ST_SZ_A, ST_SZ_B: begin addr = A_PKTSZ; wdata = 16'd1; end
      ST_CMD_A:    begin addr = A_PKT;   wdata = {8'd0, CMD_EXIT_SLEEP}; end
      ST_CMD_B:    begin addr = A_PKT;   wdata = {8'd0, CMD_DISP_ON};    end
      ST_DLY_A: begin
        kind     = K_WAIT;
        wait_cyc = WAIT_W'(dly_sleep_ms) * WAIT_W'(CYC_PER_MS);
      end
      ST_DLY_B: begin
        kind     = K_WAIT;
        wait_cyc = WAIT_W'(dly_disp_ms) * WAIT_W'(CYC_PER_MS);
      end
      ST_CFG_HS:   begin addr = A_CFG;   wdata = cfg_hs;                 end
      default:     begin kind = K_END;   next_step = ST_END;             end
    endcase
  end
endmodule

// File: rtl/bridge_bringup_seq.sv
module bridge_bringup_seq
  import bbs_pkg::*;
#(
  parameter int CLK_HZ  = 250_000_000,
  parameter int RST_MS  = 10,
  parameter int LOCK_US = 500,
  parameter int DLY_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              readback_en,
  input  logic [7:0]        hsync_len,
  input  logic [7:0]        vsync_len,
  input  logic [7:0]        hback,
  input  logic [7:0]        vback,
  input  logic [7:0]        hfront,
  input  logic [7:0]        vfront,
  input  logic [15:0]       hactive,
  input  logic [15:0]       vactive,
  input  logic [4:0]        depth,
  input  logic              loose18,
  input  logic [2:0]        lanes,
  input  logic [15:0]       pll_word,
  input  logic [15:0]       lpdiv_word,
  input  logic [15:0]       ref_khz,
  input  logic [DLY_W-1:0]  dly_sleep_ms,
  input  logic [DLY_W-1:0]  dly_disp_ms,
  output logic              acc_req,
  output logic              acc_wr,
  output logic [7:0]        acc_addr,
  output logic [15:0]       acc_wdata,
  input  logic              acc_ack,
  input  logic [15:0]       acc_rdata,
  output logic              bridge_rst_n,
  output logic              done,
  output logic              err
);
  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int RST_CYC    = CYC_PER_MS * RST_MS;
  localparam int LOCK_CYC   = CYC_PER_MS * LOCK_US / 1000;
  localparam int DLY_MAX    = CYC_PER_MS * ((1 << DLY_W) - 1);
  localparam int MAX_A      = (RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC;
  localparam int MAX_WAIT   = (MAX_A > DLY_MAX) ? MAX_A : DLY_MAX;
  localparam int WAIT_W     = $clog2(MAX_WAIT + 1);

  fsm_e               fsm;
  step_e              step, next_step;
  kind_e              kind;
  logic [AW-1:0]      d_addr;
  logic [DW-1:0]      d_wdata, d_expect, shadow;
  logic [WAIT_W-1:0]  wait_cyc;
  logic               fmt_bad, tmr_load, tmr_expired, sh_init, sh_load;

  bbs_step_decode #(
    .WAIT_W(WAIT_W), .CYC_PER_MS(CYC_PER_MS), .RST_CYC(RST_CYC),
    .LOCK_CYC(LOCK_CYC), .DLY_W(DLY_W)
  ) i_decode (
    .step(step), .readback_en(readback_en),
    .hsync_len(hsync_len), .vsync_len(vsync_len), .hback(hback), .vback(vback),
    .hfront(hfront), .vfront(vfront), .hactive(hactive), .vactive(vactive),
    .depth(depth), .loose18(loose18), .lanes(lanes), .pll_word(pll_word),
    .lpdiv_word(lpdiv_word), .ref_khz(ref_khz), .dly_sleep_ms(dly_sleep_ms),
    .dly_disp_ms(dly_disp_ms), .shadow(shadow), .kind(kind), .addr(d_addr),
    .wdata(d_wdata), .expect_val(d_expect), .wait_cyc(wait_cyc),
    .fmt_bad(fmt_bad), .next_step(next_step)
  );

  assign tmr_load = (fsm == F_PREP) && (kind == K_WAIT);

  bbs_wait_timer #(.W(WAIT_W)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .value(wait_cyc),
    .expired(tmr_expired)
  );

  assign sh_init = (fsm == F_IDLE) && start;
  assign sh_load = (fsm == F_ACC) && acc_ack && acc_wr && (acc_addr == A_CFG);

  bbs_cfg_shadow i_shadow (
    .clk(clk), .rst(rst), .init(sh_init), .load(sh_load),
    .load_val(acc_wdata), .shadow(shadow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm          <= F_IDLE;
      step         <= ST_RST_LO;
      acc_req      <= 1'b0;
      acc_wr       <= 1'b0;
      acc_addr     <= '0;
      acc_wdata    <= '0;
      bridge_rst_n <= 1'b1;
      done         <= 1'b0;
      err          <= 1'b0;
    end else begin
      case (fsm)
        F_IDLE: if (start) begin
          step <= ST_RST_LO;
          done <= 1'b0;
          err  <= 1'b0;
          fsm  <= F_PREP;
        end
        F_PREP: case (kind)
          K_WAIT: begin
            if (step == ST_RST_LO) bridge_rst_n <= 1'b0;
            fsm <= F_WAIT;
          end
          K_END: begin
            done <= 1'b1;
            fsm  <= F_IDLE;
          end
          default: begin
            if (step == ST_FMT && fmt_bad) begin
              err <= 1'b1;
              fsm <= F_IDLE;
            end else begin
              acc_req   <= 1'b1;
              acc_wr    <= (kind == K_WRITE);
              acc_addr  <= d_addr;
              acc_wdata <= d_wdata;
              fsm       <= F_ACC;
            end
          end
        endcase
        F_ACC: if (acc_ack) begin
          acc_req <= 1'b0;
          if (!acc_wr && acc_rdata != d_expect) begin
            err <= 1'b1;
            fsm <= F_IDLE;
          end else begin
            step <= next_step;
            fsm  <= F_PREP;
          end
        end
        default: if (tmr_expired) begin
          if (step == ST_RST_LO) bridge_rst_n <= 1'b1;
          step <= next_step;
          fsm  <= F_PREP;
        end
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_ack) |=> (acc_req && $stable(acc_addr) &&
                               $stable(acc_wdata) && $stable(acc_wr)));
  assert_req_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_ack) |=> !acc_req);
  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    !bridge_rst_n |-> !acc_req);
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  assert_cfg_write_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_wr && acc_addr == A_CFG) |-> (acc_wdata[CB_CMDSET] && acc_wdata[CB_HSCLK]));
  assert_fmt_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_wr && acc_addr == A_FMT) |-> (acc_wdata[15:2] == 14'd2));
  assert_no_req_waiting_R8: assert property (@(posedge clk) disable iff (rst)
    (fsm == F_WAIT) |-> !acc_req);
endmodule

// File: tb/test_bridge_bringup_seq.sv
module test_bridge_bringup_seq;
  // delay base scaled down: 100 clocks per millisecond
  localparam int CLK_HZ   = 100_000;
  localparam int CPM      = CLK_HZ / 1000;
  localparam int RST_CYC  = CPM * 10;
  localparam int LOCK_CYC = CPM * 500 / 1000;

  logic clk = 0, rst = 1, start = 0;
  logic readback_en = 0, loose18 = 0;
  logic [7:0] hsync_len = 0, vsync_len = 0, hback = 0, vback = 0, hfront = 0, vfront = 0;
  logic [15:0] hactive = 0, vactive = 0, pll_word = 0, lpdiv_word = 0, ref_khz = 0;
  logic [4:0] depth = 24;
  logic [2:0] lanes = 4;
  logic [7:0] dly_sleep_ms = 0, dly_disp_ms = 0;
  logic acc_req, acc_wr, acc_ack = 0, bridge_rst_n, done, err;
  logic [7:0] acc_addr;
  logic [15:0] acc_wdata, acc_rdata = 0;

  bridge_bringup_seq #(.CLK_HZ(CLK_HZ)) i_bridge_bringup_seq (
    .clk(clk), .rst(rst), .start(start), .readback_en(readback_en),
    .hsync_len(hsync_len), .vsync_len(vsync_len), .hback(hback), .vback(vback),
    .hfront(hfront), .vfront(vfront), .hactive(hactive), .vactive(vactive),
    .depth(depth), .loose18(loose18), .lanes(lanes), .pll_word(pll_word),
    .lpdiv_word(lpdiv_word), .ref_khz(ref_khz), .dly_sleep_ms(dly_sleep_ms),
    .dly_disp_ms(dly_disp_ms), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
    .acc_rdata(acc_rdata), .bridge_rst_n(bridge_rst_n), .done(done), .err(err)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [24:0] log_ent [0:31];
  int req_cyc [0:31];
  int ack_cyc [0:31];
  int log_n = 0;
  logic [24:0] exp_ent [0:31];
  int exp_n = 0;
  logic [15:0] resp_id = 16'h2828, resp_cfg = 16'h0301;
  int lat = 0, low_cnt = 0, rise_cyc = -1, first_req = -1, hold_viol = 0;
  bit pend = 0, prev_req = 0, prev_ack = 0, prev_rstn = 1;
  logic [24:0] prev_fields = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv,
                     input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // model of the register access master
  always @(negedge clk) begin
    cyc++;
    if (!bridge_rst_n) low_cnt++;
    if (bridge_rst_n && !prev_rstn) rise_cyc = cyc;
    prev_rstn = bridge_rst_n;
    if (acc_req && first_req < 0) first_req = cyc;
    if (prev_req && !prev_ack && (!acc_req || {acc_wr, acc_addr, acc_wdata} != prev_fields))
      hold_viol++;
    prev_req = acc_req;
    prev_fields = {acc_wr, acc_addr, acc_wdata};
    if (acc_ack) acc_ack = 0;
    else if (acc_req) begin
      if (!pend) begin
        pend = 1;
        lat = $urandom_range(0, 3);
        if (log_n < 32) req_cyc[log_n] = cyc;
      end
      if (lat == 0) begin
        if (log_n < 32) begin
          log_ent[log_n] = acc_wr ? {1'b1, acc_addr, acc_wdata} : {1'b0, acc_addr, 16'h0};
          ack_cyc[log_n] = cyc;
        end
        log_n++;
        acc_rdata = (acc_addr == 8'hB0) ? resp_id : (acc_addr == 8'hB7) ? resp_cfg : 16'h0;
        acc_ack = 1;
        pend = 0;
      end else lat--;
    end
    prev_ack = acc_ack;
  end

  task automatic push(input logic wr, input logic [7:0] a, input logic [15:0] d);
    exp_ent[exp_n] = {wr, a, d};
    exp_n++;
  endtask

  // expected access list built from the requirements
  task automatic build_expected(output bit exp_err, output bit full);
    logic [1:0] fmt;
    bit bad;
    logic [15:0] css;
    logic [7:0] hs, vs;
    exp_n = 0; exp_err = 0; full = 0;
    if (readback_en) begin
      push(0, 8'hB0, 0);
      if (resp_id != 16'h2828) begin exp_err = 1; return; end
      push(0, 8'hB7, 0);
      if (resp_cfg != 16'h0301) begin exp_err = 1; return; end
    end
    hs = hsync_len + hback; vs = vsync_len + vback;
    push(1, 8'hB1, {vsync_len, hsync_len});
    push(1, 8'hB2, {vs, hs});
    push(1, 8'hB3, {vfront, hfront});
    push(1, 8'hB4, hactive);
    push(1, 8'hB5, vactive);
    bad = 0; fmt = 0;
    if (depth == 16) fmt = 0;
    else if (depth == 18) fmt = loose18 ? 2 : 1;
    else if (depth == 24) fmt = 3;
    else bad = 1;
    if (bad) begin exp_err = 1; return; end
    push(1, 8'hB6, {12'd0, 2'd2, fmt});
    push(1, 8'hDE, {13'd0, lanes - 3'd1});
    css = (ref_khz == 0) ? 16'h0020 : 16'h0000;
    push(1, 8'hB7, 16'h0342 | css);
    push(1, 8'hBA, pll_word);
    push(1, 8'hB8, 16'h0);
    push(1, 8'hBB, lpdiv_word);
    push(1, 8'hB9, 16'h1);
    push(1, 8'hBC, 16'h1);
    push(1, 8'hBF, 16'h11);
    push(1, 8'hBC, 16'h1);
    push(1, 8'hBF, 16'h29);
    push(1, 8'hB7, 16'h034B | css);
    full = 1;
  endtask

  function automatic string tag_of(input logic [24:0] e);
    case (e[23:16])
      8'hB0: return "R3";
      8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5: return "R4";
      8'hB6: return "R5";
      8'hDE: return "R6";
      8'hB7: return !e[24] ? "R3" : (e[0] ? "R10" : "R7");
      8'hBC, 8'hBF: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic run_seq(input int mid_start, input string etag, input string lbl);
    bit exp_err, full, fin;
    int base, g;
    log_n = 0; low_cnt = 0; rise_cyc = -1; first_req = -1; hold_viol = 0;
    build_expected(exp_err, full);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    fin = 0;
    for (int w = 0; w < 20000 && !fin; w++) begin
      @(negedge clk);
      start = (mid_start != 0 && w == mid_start);
      if (done || err) fin = 1;
    end
    start = 0;
    if (!fin) begin
      fails++; checks++;
      $display("FAIL R10 %s watchdog actual=%h expected=%h", lbl, 0, 1);
    end
    chk(etag, log_n, exp_n, {lbl, " access count"});
    for (int i = 0; i < exp_n && i < log_n && i < 32; i++)
      chk(tag_of(exp_ent[i]), log_ent[i], exp_ent[i], lbl);
    chk("R10", done, !exp_err, {lbl, " done"});
    chk(etag, err, exp_err, {lbl, " err"});
    chk("R11", hold_viol, 0, {lbl, " request hold"});
    chk("R2", (low_cnt >= RST_CYC && low_cnt <= RST_CYC + 3), 1, {lbl, " reset low width"});
    if (first_req >= 0)
      chk("R2", (first_req - rise_cyc >= RST_CYC), 1, {lbl, " release to first access"});
    if (full && log_n == exp_n) begin
      base = readback_en ? 2 : 0;
      g = req_cyc[base+12] - ack_cyc[base+11];
      chk("R8", (g >= LOCK_CYC && g <= LOCK_CYC + 6), 1, {lbl, " lock wait"});
      g = req_cyc[base+14] - ack_cyc[base+13];
      chk("R9", (g >= dly_sleep_ms*CPM && g <= dly_sleep_ms*CPM + 6), 1, {lbl, " sleep wait"});
      g = req_cyc[base+16] - ack_cyc[base+15];
      chk("R9", (g >= dly_disp_ms*CPM && g <= dly_disp_ms*CPM + 6), 1, {lbl, " display wait"});
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_panel(input logic [7:0] hs, vs, hb, vb, hf, vf,
                           input logic [15:0] x, y);
    hsync_len = hs; vsync_len = vs; hback = hb; vback = vb;
    hfront = hf; vfront = vf; hactive = x; vactive = y;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {done, err, acc_req, bridge_rst_n}, 4'b0001, "reset outputs");

    // full run with readback, 24-bit, four lanes, external reference
    readback_en = 1; depth = 24; lanes = 4; ref_khz = 16'd24000;
    pll_word = 16'h4214; lpdiv_word = 16'h0005; dly_sleep_ms = 2; dly_disp_ms = 3;
    set_panel(8'd10, 8'd2, 8'd40, 8'd20, 8'd30, 8'd8, 16'd800, 16'd480);
    run_seq(0, "R3", "readback_24bpp");

    // no readback, loose 18-bit, one lane, pixel-clock reference, zero delays; sums wrap
    readback_en = 0; depth = 18; loose18 = 1; lanes = 1; ref_khz = 0;
    dly_sleep_ms = 0; dly_disp_ms = 0;
    set_panel(8'd200, 8'd250, 8'd100, 8'd10, 8'd1, 8'd2, 16'd1280, 16'd720);
    run_seq(0, "R7", "pclk_ref_loose18");

    // wrong identity
    readback_en = 1; resp_id = 16'h1234;
    run_seq(0, "R3", "bad_identity");
    resp_id = 16'h2828;

    // configuration readback mismatch
    resp_cfg = 16'h0300;
    run_seq(0, "R3", "bad_cfg_readback");
    resp_cfg = 16'h0301;

    // unsupported depth
    readback_en = 0; depth = 20;
    run_seq(0, "R5", "bad_depth");

    // start pulse during a run is ignored (R12), then a clean packed 18-bit run
    depth = 18; loose18 = 0; lanes = 2; ref_khz = 16'd27000; dly_sleep_ms = 1; dly_disp_ms = 1;
    run_seq(1500, "R12", "start_while_busy");

    // random configurations
    for (int k = 0; k < 5; k++) begin
      readback_en = $urandom_range(0, 1);
      case ($urandom_range(0, 2)) 0: depth = 16; 1: depth = 18; default: depth = 24; endcase
      loose18 = $urandom_range(0, 1);
      lanes = 3'($urandom_range(1, 4));
      ref_khz = ($urandom_range(0, 1) == 0) ? 16'd0 : 16'($urandom_range(1, 60000));
      pll_word = 16'($urandom); lpdiv_word = 16'($urandom_range(0, 63));
      dly_sleep_ms = 8'($urandom_range(0, 3)); dly_disp_ms = 8'($urandom_range(0, 3));
      set_panel(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom));
      run_seq(0, "R4", "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    fails++; checks++;
    $display("FAIL R10 global watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule